// File: doc/BRIEF.md
# PHY Parameter Override Sequencer

This block reprograms three analog tuning settings inside a SuperSpeed serial PHY once the host controller has come out of reset. The PHY drops these settings back to their defaults on every controller reset. The system therefore pulses `start_i` after each host reset completes, and again after every bus resume. The sequencer then performs three writes, always in the same order, through a generic write-request port. First it overrides the loss-of-signal detector, then it raises the transmit boost level, and last it sets the receiver-detect measurement time. That last value depends on which reference clock the PHY runs from.

Each write shows an address and a data word with `wr_valid_o` and holds them until `wr_ready_i`. It then waits for the port master to return `wr_done_i`, which comes with `wr_err_i` when the write failed (for example, a handshake timeout). A failed write ends the sequence at once. A reference-clock code with no defined measurement time also ends the sequence in error, but only after the first two writes have been made. When the block finishes it holds either `done_o` or `err_o` until the next accepted start.

The control machine has three states. IDLE waits for a start. ISSUE hands the current step's address and data to the port. WAIT holds until the port reports a response. Its transitions are as follows:
- IDLE→ISSUE on start.
- ISSUE→WAIT when a write is launched.
- ISSUE→IDLE (error) at the third step when the clock code is unsupported.
- WAIT→ISSUE on a good response to step one or step two.
- WAIT→IDLE (done) on a good response to step three.
- WAIT→IDLE (error) on a failed response.

The port machine has three states: PIDLE, PREQ (valid shown), and PWAIT (accepted, waiting for the response). It moves PIDLE→PREQ on a launch, PREQ→PWAIT on ready, and PWAIT→PIDLE on done.

Top module: `phy_ovrd_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `wr_valid_o` are all low.
- R2: A `start_i` high at a clock edge while idle makes `busy_o` high and clears `done_o` and `err_o` at that same edge. The reference-clock code is captured at that edge, and later changes of `ref_sel_i` do not affect the run.
- R3: The writes go to addresses 0x0015, 0x0012 and 0x1010, in that order and never in any other.
- R4: The first write (loss-of-signal override) carries data 0xA409. This is bias 0x5 in bits 15:13, the override enable in bit 10, and level 0x9 in bits 4:0.
- R5: The second write (transmit boost override) carries data 0xA000, which is boost level 0x5 in bits 15:13.
- R6: The third write carries the measurement time shifted left by 4. The time is 0x4 for codes 0 (19.2 MHz) and 1 (20 MHz); 0x8 for codes 2, 3 and 4 (24, 25 and 26 MHz); 0x20 for codes 5 to 8 (48, 50, 52 and 62.5 MHz); and 0x40 for codes 9 and 10 (96 and 100 MHz).
- R7: While `wr_valid_o` is high and `wr_ready_i` is low, the valid, address and data outputs hold steady. A new write is launched only after the previous one has returned `wr_done_i`, and valid is only ever high while busy.
- R8: A response with `wr_err_i` high sets `err_o`, drops `busy_o`, and no further write is issued.
- R9: Codes 11 to 15 give the first two writes, no third write, and then `err_o`.
- R10: `start_i` while busy is ignored: the run is neither restarted nor extended.
- R11: The sequence can be run again, without a reset, after it has ended in done or in error. This is the case used on bus resume.
- R12: `done_o` and `err_o` are never high together. Whichever one is set stays set, with `busy_o` and `wr_valid_o` low, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| ref_sel_i | input | SEL_W | Reference clock frequency code |
| wr_valid_o | output | 1 | Write request valid |
| wr_addr_o | output | ADDR_W | Internal PHY register address |
| wr_data_o | output | DATA_W | Internal PHY register data |
| wr_ready_i | input | 1 | Port master accepts the request |
| wr_done_i | input | 1 | Port master completion strobe |
| wr_err_i | input | 1 | Completion carries a failure, qualified by `wr_done_i` |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished with all writes good |
| err_o | output | 1 | Sequence aborted on a failed write or an unsupported code |

## Verification
The assertions rely on the port master obeying the request protocol. It asserts `wr_ready_i` only while `wr_valid_o` is high, and it raises `wr_done_i` only after a write has been accepted and before the next one is shown. The bench's responder model keeps to this for every combination of ready delay and done delay it uses. The bench sweeps all sixteen clock codes against error injection on each of the three writes. It also drives `start_i` during each run and changes `ref_sel_i` after each start, so that the ignore and capture rules are exercised while the port traffic is live.

// File: rtl/phy_ovrd_pkg.sv
package phy_ovrd_pkg;

    typedef enum logic [1:0] {
        STEP_LOS   = 2'd0,
        STEP_BOOST = 2'd1,
        STEP_RXDET = 2'd2
    } step_e;

    typedef enum logic [1:0] {
        C_IDLE  = 2'd0,
        C_ISSUE = 2'd1,
        C_WAIT  = 2'd2
    } ctrl_e;

    typedef enum logic [1:0] {
        P_IDLE = 2'd0,
        P_REQ  = 2'd1,
        P_WAIT = 2'd2
    } port_e;

endpackage

// File: rtl/ovrd_value_table.sv
module ovrd_value_table
    import phy_ovrd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int SEL_W  = 4
) (
    input  step_e             step_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              sel_ok_o
);
    localparam logic [ADDR_W-1:0] LOS_ADDR   = ADDR_W'(16'h0015);
    localparam logic [ADDR_W-1:0] BOOST_ADDR = ADDR_W'(16'h0012);
    localparam logic [ADDR_W-1:0] RXDET_ADDR = ADDR_W'(16'h1010);
    localparam int LOS_BIAS_LSB   = 13;
    localparam int LOS_EN_BIT     = 10;
    localparam int BOOST_LSB      = 13;
    localparam int MEAS_LSB       = 4;
    localparam logic [DATA_W-1:0] LOS_DATA =
        (DATA_W'(3'd5) << LOS_BIAS_LSB) | (DATA_W'(1'b1) << LOS_EN_BIT) | DATA_W'(5'd9);
    localparam logic [DATA_W-1:0] BOOST_DATA = DATA_W'(3'd5) << BOOST_LSB;

    logic [6:0] meas;

    // Receiver-detect measurement time per reference clock code
    always_comb begin
        meas     = 7'd0;
        sel_ok_o = 1'b1;
        case (32'(sel_i))
            0, 1:       meas = 7'h04;
            2, 3, 4:    meas = 7'h08;
            5, 6, 7, 8: meas = 7'h20;
            9, 10:      meas = 7'h40;
            default:    sel_ok_o = 1'b0;
        endcase
    end

    always_comb begin
        unique case (step_i)
            STEP_LOS: begin
                addr_o = LOS_ADDR;
                data_o = LOS_DATA;
            end
            STEP_BOOST: begin
                addr_o = BOOST_ADDR;
                data_o = BOOST_DATA;
            end
            STEP_RXDET: begin
                addr_o = RXDET_ADDR;
                data_o = DATA_W'(meas) << MEAS_LSB;
            end
            default: begin
                addr_o = '0;
                data_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/ovrd_wr_port.sv
module ovrd_wr_port
    import phy_ovrd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              rsp_vld_o,
    output logic              rsp_err_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic              wr_ready_i,
    input  logic              wr_done_i,
    input  logic              wr_err_i
);
    port_e             state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= P_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_IDLE:  if (go_i)       state_d = P_REQ;
            P_REQ:   if (wr_ready_i) state_d = P_WAIT;
            P_WAIT:  if (wr_done_i)  state_d = P_IDLE;
            default:                 state_d = P_IDLE;
        endcase
    end

    // Request payload is captured at launch and held for the whole write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (state_q == P_IDLE && go_i) begin
            addr_q <= addr_i;
            data_q <= data_i;
        end
    end

    always_comb begin
        wr_valid_o = (state_q == P_REQ);
        wr_addr_o  = addr_q;
        wr_data_o  = data_q;
        rsp_vld_o  = (state_q == P_WAIT) && wr_done_i;
        rsp_err_o  = (state_q == P_WAIT) && wr_done_i && wr_err_i;
    end
endmodule

// File: rtl/ovrd_ctrl_fsm.sv
module ovrd_ctrl_fsm
    import phy_ovrd_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             sel_ok_i,
    input  logic             rsp_vld_i,
    input  logic             rsp_err_i,
    output step_e            step_o,
    output logic [SEL_W-1:0] sel_q_o,
    output logic             go_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    ctrl_e state_q, state_d;
    logic  last_step;

    assign last_step = (step_o == STEP_RXDET);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE:  if (start_i) state_d = C_ISSUE;
            C_ISSUE: state_d = (last_step && !sel_ok_i) ? C_IDLE : C_WAIT;
            C_WAIT: begin
                if (rsp_vld_i) begin
                    if (rsp_err_i || last_step) state_d = C_IDLE;
                    else                        state_d = C_ISSUE;
                end
            end
            default: state_d = C_IDLE;
        endcase
    end

    // Registered outputs: step pointer, captured clock code, result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_o  <= STEP_LOS;
            sel_q_o <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            unique case (state_q)
                C_IDLE: if (start_i) begin
                    step_o  <= STEP_LOS;
                    sel_q_o <= sel_i;
                    done_o  <= 1'b0;
                    err_o   <= 1'b0;
                end
                C_ISSUE: if (last_step && !sel_ok_i) err_o <= 1'b1;
                C_WAIT: if (rsp_vld_i) begin
                    if (rsp_err_i)      err_o  <= 1'b1;
                    else if (last_step) done_o <= 1'b1;
                    else                step_o <= step_e'(step_o + 2'd1);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy_o = (state_q != C_IDLE);
        go_o   = (state_q == C_ISSUE) && !(last_step && !sel_ok_i);
    end
endmodule

// File: rtl/phy_ovrd_seq.sv
module phy_ovrd_seq
    import phy_ovrd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEL_W-1:0]  ref_sel_i,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic              wr_ready_i,
    input  logic              wr_done_i,
    input  logic              wr_err_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    step_e             step;
    logic [SEL_W-1:0]  sel_q;
    logic              sel_ok;
    logic              go;
    logic              rsp_vld;
    logic              rsp_err;
    logic [ADDR_W-1:0] tab_addr;
    logic [DATA_W-1:0] tab_data;

    ovrd_ctrl_fsm #(.SEL_W(SEL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .sel_i     (ref_sel_i),
        .sel_ok_i  (sel_ok),
        .rsp_vld_i (rsp_vld),
        .rsp_err_i (rsp_err),
        .step_o    (step),
        .sel_q_o   (sel_q),
        .go_o      (go),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .err_o     (err_o)
    );

    ovrd_value_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_tab (
        .step_i   (step),
        .sel_i    (sel_q),
        .addr_o   (tab_addr),
        .data_o   (tab_data),
        .sel_ok_o (sel_ok)
    );

    ovrd_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go),
        .addr_i     (tab_addr),
        .data_i     (tab_data),
        .rsp_vld_o  (rsp_vld),
        .rsp_err_o  (rsp_err),
        .wr_valid_o (wr_valid_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .wr_ready_i (wr_ready_i),
        .wr_done_i  (wr_done_i),
        .wr_err_i   (wr_err_i)
    );
endmodule

// File: rtl/phy_ovrd_seq_chk.sv
module phy_ovrd_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              wr_valid_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [DATA_W-1:0] wr_data_o,
    input logic              wr_ready_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o
);
    p_rst_idle_r1: assert property (@(posedge clk) !rst_n |-> !busy_o && !done_o && !err_o && !wr_valid_o);

    p_start_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o && !done_o && !err_o);

    p_legal_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> (wr_addr_o == ADDR_W'(16'h0015)) || (wr_addr_o == ADDR_W'(16'h0012))
                       || (wr_addr_o == ADDR_W'(16'h1010)));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

    p_valid_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> busy_o);

    p_flags_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    p_flags_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |-> !busy_o && !wr_valid_o);

    p_flag_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) && !start_i |=> $stable(done_o) && $stable(err_o));
endmodule

bind phy_ovrd_seq phy_ovrd_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .wr_ready_i (wr_ready_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/phy_ovrd_seq_bench.sv
`timescale 1ns/1ps
module phy_ovrd_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  sel = 4'd0;
    logic        wr_valid;
    logic [15:0] wr_addr;
    logic [15:0] wr_data;
    logic        wr_ready = 1'b0;
    logic        wr_done = 1'b0;
    logic        wr_err = 1'b0;
    logic        busy, done, err;

    int n_chk = 0;
    int n_fail = 0;
    int rdly_g = 0, ddly_g = 0, inj_g = 0, ncap = 0;
    logic [15:0] cap_a [8];
    logic [15:0] cap_d [8];

    always #2.5 clk = ~clk;

    phy_ovrd_seq u_phy_ovrd_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .ref_sel_i  (sel),
        .wr_valid_o (wr_valid),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .wr_ready_i (wr_ready),
        .wr_done_i  (wr_done),
        .wr_err_i   (wr_err),
        .busy_o     (busy),
        .done_o     (done),
        .err_o      (err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Port master model: ready after rdly_g cycles, done after ddly_g more
    initial begin
        int rs = 0;
        int cnt = 0;
        forever begin
            @(negedge clk);
            wr_ready = 1'b0;
            wr_done  = 1'b0;
            wr_err   = 1'b0;
            if (rs == 0 && rst_n && wr_valid) begin
                if (rdly_g == 0) rs = 3;
                else begin cnt = rdly_g; rs = 1; end
            end else if (rs == 1) begin
                cnt--;
                if (cnt == 0) rs = 3;
            end else if (rs == 2) begin
                if (cnt == 0) begin
                    wr_done = 1'b1;
                    wr_err  = (inj_g == ncap);
                    rs = 0;
                end else cnt--;
            end
            if (rs == 3) begin
                wr_ready = 1'b1;
                if (ncap < 8) begin
                    cap_a[ncap] = wr_addr;
                    cap_d[ncap] = wr_data;
                end
                ncap++;
                cnt = ddly_g;
                rs = 2;
            end
        end
    end

    function automatic int meas_of(input int code);
        if (code <= 1)  return 'h04;
        if (code <= 4)  return 'h08;
        if (code <= 8)  return 'h20;
        return 'h40;
    endfunction

    task automatic run(input int code, input int inj, input int rd, input int dd);
        bit sup;
        int max_n, exp_n, guard;
        bit exp_err;
        int exp_a [3];
        int exp_d [3];
        rdly_g = rd; ddly_g = dd; inj_g = inj; ncap = 0;
        sup   = (code <= 10);
        max_n = sup ? 3 : 2;
        if (inj >= 1 && inj <= max_n) begin exp_n = inj; exp_err = 1'b1; end
        else begin exp_n = max_n; exp_err = !sup; end
        exp_a[0] = 'h0015; exp_d[0] = (5 << 13) + (1 << 10) + 9;
        exp_a[1] = 'h0012; exp_d[1] = 5 << 13;
        exp_a[2] = 'h1010; exp_d[2] = sup ? (meas_of(code) << 4) : 0;

        sel = 4'(code);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sel = 4'(code ^ 5);   // R2: code captured at start, later changes ignored
        chk(busy == 1'b1, "R2 busy", int'(busy), 1);
        chk(!done && !err, "R2 flags cleared", int'({done, err}), 0);
        start = 1'b1;         // R10: start while busy must be ignored
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (busy && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 300, "R12 run ends", guard, 0);
        repeat (4) @(negedge clk);
        // R8 R9 R10: number of writes issued
        chk(ncap == exp_n, "R8/R9/R10 write count", ncap, exp_n);
        for (int i = 0; i < 3; i++) begin
            if (i < exp_n && i < ncap) begin
                chk(int'(cap_a[i]) == exp_a[i], "R3 address order", int'(cap_a[i]), exp_a[i]);
                if (i == 0) chk(int'(cap_d[i]) == exp_d[i], "R4 los data", int'(cap_d[i]), exp_d[i]);
                if (i == 1) chk(int'(cap_d[i]) == exp_d[i], "R5 boost data", int'(cap_d[i]), exp_d[i]);
                if (i == 2) chk(int'(cap_d[i]) == exp_d[i], "R6 rxdet data", int'(cap_d[i]), exp_d[i]);
            end
        end
        chk(err == exp_err, "R8/R9 err", int'(err), int'(exp_err));
        chk(done == !exp_err, "R12 done", int'(done), int'(!exp_err));
        chk(!busy && !wr_valid, "R12 quiet", int'({busy, wr_valid}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !wr_valid, "R1 reset state",
            int'({busy, done, err, wr_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !wr_valid, "R1 idle after release", int'({busy, wr_valid}), 0);
        // R11: every run after the first reruns without a reset
        for (int code = 0; code < 16; code++) begin
            for (int inj = 0; inj < 4; inj++) begin
                run(code, inj, (code + inj) % 3, code % 2);
            end
        end
        summary();
    end
endmodule